// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a three-phase PWM timing core and the gate drivers. It stops the power stage when any of three shutdown sources fires. The first source is an active-low trip pin from outside the chip. The second is an active-low trip from the DC-bus current-sense comparator. The third is a single software shutdown bit. All three act the same way. A falling edge on either trip line, or a write to the software bit, latches the shutdown. The six gate outputs then go to their idle level, and the timing core is disabled.

Software reads a one-bit flag to tell a software-initiated shutdown from a hardware trip. Reading the flag clears it. Restart takes two things. First, both trip lines must be back high. Second, after that, software must write the period register and all three phase duty registers. The block then re-arms and enables the timing core, but it keeps the gates at idle until the next rising edge of the sync pulse. That edge latches the new duties and hands the gates back to the timing core.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: A falling edge on `trip_ext_ni` passes through a two-flop synchroniser and then an edge detector. If the low level is first sampled at clock edge k, `shutdown_o` reads 1 after edge k+2, and not before.
- R2: A falling edge on `isense_trip_ni` is sampled directly, with no synchroniser. If the low level is first sampled at edge k, `shutdown_o` reads 1 after edge k.
- R3: A one-cycle pulse on `sw_shut_wr_i` at edge k sets `shutdown_o` after edge k.
- R4: `sw_flag_o` is set by `sw_shut_wr_i` and never by a hardware trip. A cycle with `sw_flag_rd_i` high returns the current flag on `sw_flag_o` and clears it after that edge. If a write and a read fall in the same cycle, the flag stays set. The flag is 0 after reset.
- R5: `gate_o` is a register. After each edge it holds the previous cycle's `gate_i`, unless that cycle had a trigger or the block was not running. In either of those cases it holds the idle level, which is all zeros by default. It is all zeros after reset.
- R6: Restart needs one write to each timing register. Bit 0 of `tim_reg_we_i` is the period register, and bits 1 to 3 are the phase A, B and C duty registers. Writes count only while both trip lines read high, the external one after synchronisation. Three of the four writes are not enough to re-arm.
- R7: The write of the last missing register is sampled at edge k, with both trips high. After edge k+1, `shutdown_o` is 0 and the block is armed.
- R8: When the block is not shut down, `duty_latch_o` is high in any cycle where `sync_i` is high and was low at the previous edge. In the armed state, that edge also hands `gate_o` back to `gate_i` from the following cycle on. A new trigger while armed returns the block to shutdown.
- R9: `timer_en_o` is low exactly while `shutdown_o` is high. Otherwise it is high, including after reset.
- R10: If a trip line goes low again while the block is shut down, all register writes recorded so far are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trip_ext_ni | input | 1 | External trip, active low, asynchronous |
| isense_trip_ni | input | 1 | Current-sense comparator trip, active low, synchronous |
| sw_shut_wr_i | input | 1 | Software shutdown write strobe |
| sw_flag_rd_i | input | 1 | Read strobe for the software-source flag (clears it) |
| sw_flag_o | output | 1 | Flag: last shutdown was requested by software |
| tim_reg_we_i | input | 4 | Write strobes: bit 0 period, bits 1..3 duty A..C |
| sync_i | input | 1 | PWM sync pulse from the timing core |
| gate_i | input | 6 | Gate pattern from the timing core |
| gate_o | output | 6 | Gate drive outputs |
| timer_en_o | output | 1 | Timing core enable |
| duty_latch_o | output | 1 | Latch new duty values (sync rising edge) |
| shutdown_o | output | 1 | Shutdown latched |

## Verification
The assertions run on every cycle. They check four relations. A trigger from any source latches the shutdown on the next edge. The gates stay at idle whenever the shutdown is latched. The block re-arms only with a full write mask and both trips clear. An armed sync edge always resumes the run state. They also check that a read empties the flag and that a fault drop clears the mask. The bench's scenarios cover what no single-cycle property can show. They count the exact latency through the synchroniser. They show that three writes are not enough to restart. They show that writes made before a repeated trip are forgotten. They also cover the ordering of flag reads against writes, and a new trigger that arrives while the block is armed.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SHUT  = 2'd1,
    ST_ARMED = 2'd2
  } fault_state_e;

endpackage

// File: rtl/pft_edge_in.sv
// Optional synchroniser chain followed by a falling-edge detector.
module pft_edge_in #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic level_o,
  output logic fall_o
);

  logic level;
  logic prev_q;

  if (STAGES == 0) begin : g_direct
    assign level = in_i;
  end else begin : g_sync
    logic [STAGES-1:0] sh_q;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[s] <= RST_VAL;
          else         sh_q[s] <= in_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[s] <= RST_VAL;
          else         sh_q[s] <= sh_q[s-1];
        end
      end
    end
    assign level = sh_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= level;
  end

  assign level_o = level;
  assign fall_o  = prev_q & ~level;

endmodule

// File: rtl/pft_rearm_mask.sv
// Records which timing registers were rewritten during a shutdown.
module pft_rearm_mask #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         enable_i,
  input  logic [N-1:0] we_i,
  output logic         full_o
);

  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (clear_i)  mask_q <= '0;
    else if (enable_i) mask_q <= mask_q | we_i;
  end

  assign full_o = &mask_q;

endmodule

// File: rtl/pft_gate_out.sv
// Registered gate stage; forced to the idle pattern on request.
module pft_gate_out #(
  parameter int unsigned W    = 6,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         force_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] gate_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_o <= IDLE;
    else if (force_i) gate_o <= IDLE;
    else              gate_o <= gate_i;
  end

endmodule

// File: rtl/pwm_fault_ctrl.sv
module pwm_fault_ctrl
  import pwm_fault_pkg::*;
#(
  parameter int unsigned            NUM_PHASES  = 3,
  parameter int unsigned            SYNC_STAGES = 2,
  parameter logic [2*NUM_PHASES-1:0] GATE_IDLE  = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trip_ext_ni,
  input  logic                      isense_trip_ni,
  input  logic                      sw_shut_wr_i,
  input  logic                      sw_flag_rd_i,
  output logic                      sw_flag_o,
  input  logic [NUM_PHASES:0]       tim_reg_we_i,
  input  logic                      sync_i,
  input  logic [2*NUM_PHASES-1:0]   gate_i,
  output logic [2*NUM_PHASES-1:0]   gate_o,
  output logic                      timer_en_o,
  output logic                      duty_latch_o,
  output logic                      shutdown_o
);

  localparam int unsigned NUM_GATES = 2 * NUM_PHASES;
  localparam int unsigned NUM_REGS  = NUM_PHASES + 1;

  fault_state_e state_q, state_d;
  logic ext_level, ext_fall;
  logic is_level, is_fall;
  logic fault_ok, trig, mask_full;
  logic sync_prev_q, sync_rise;
  logic flag_q;

  pft_edge_in #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext (
    .clk_i, .rst_ni, .in_i(trip_ext_ni), .level_o(ext_level), .fall_o(ext_fall)
  );

  // comparator output is already in this clock domain
  pft_edge_in #(.STAGES(0), .RST_VAL(1'b1)) u_isense (
    .clk_i, .rst_ni, .in_i(isense_trip_ni), .level_o(is_level), .fall_o(is_fall)
  );

  assign fault_ok = ext_level & is_level;
  assign trig     = ext_fall | is_fall | sw_shut_wr_i;

  pft_rearm_mask #(.N(NUM_REGS)) u_mask (
    .clk_i, .rst_ni,
    .clear_i (trig | ~fault_ok | (state_q != ST_SHUT)),
    .enable_i(state_q == ST_SHUT),
    .we_i    (tim_reg_we_i),
    .full_o  (mask_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_prev_q <= 1'b0;
    else         sync_prev_q <= sync_i;
  end
  assign sync_rise = sync_i & ~sync_prev_q;

  always_comb begin
    state_d = state_q;
    if (trig) begin
      state_d = ST_SHUT;
    end else begin
      unique case (state_q)
        ST_SHUT:  if (fault_ok && mask_full) state_d = ST_ARMED;
        ST_ARMED: if (sync_rise)             state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // software-source flag: set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flag_q <= 1'b0;
    else if (sw_shut_wr_i) flag_q <= 1'b1;
    else if (sw_flag_rd_i) flag_q <= 1'b0;
  end

  pft_gate_out #(.W(NUM_GATES), .IDLE(GATE_IDLE)) u_gate (
    .clk_i, .rst_ni,
    .force_i(trig | (state_q != ST_RUN)),
    .gate_i (gate_i),
    .gate_o (gate_o)
  );

  assign sw_flag_o    = flag_q;
  assign shutdown_o   = (state_q == ST_SHUT);
  assign timer_en_o   = (state_q != ST_SHUT);
  assign duty_latch_o = sync_rise & (state_q != ST_SHUT);

  a_r1_ext_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |=> shutdown_o);

  a_r2_isense_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_fall |=> shutdown_o);

  a_r3_sw_shut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_shut_wr_i |=> shutdown_o);

  a_r4_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_flag_rd_i && !sw_shut_wr_i) |=> !sw_flag_o);

  a_r5_gates_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (gate_o == GATE_IDLE));

  a_r7_rearm_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && $past(state_q) == ST_SHUT) |-> $past(mask_full && fault_ok));

  a_r8_sync_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && sync_rise && !trig) |=> (state_q == ST_RUN));

  a_r10_mask_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHUT && !fault_ok) |=> !mask_full);

endmodule

// File: tb/pwm_fault_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_fault_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip_ext_n = 1'b1;
  logic       isense_n = 1'b1;
  logic       sw_wr = 1'b0;
  logic       sw_rd = 1'b0;
  logic [3:0] we = '0;
  logic       sync = 1'b0;
  logic [5:0] gate_in = 6'h15;
  logic       sw_flag, timer_en, duty_latch, shutdown;
  logic [5:0] gate_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_fault_ctrl u_pwm_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .trip_ext_ni(trip_ext_n), .isense_trip_ni(isense_n),
    .sw_shut_wr_i(sw_wr), .sw_flag_rd_i(sw_rd), .sw_flag_o(sw_flag),
    .tim_reg_we_i(we), .sync_i(sync), .gate_i(gate_in), .gate_o(gate_out),
    .timer_en_o(timer_en), .duty_latch_o(duty_latch), .shutdown_o(shutdown)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 run, 1 shut, 2 armed
  int         m_state;
  bit         hist[$];
  bit         m_is_prev, m_sync_prev, m_flag;
  logic [3:0] m_mask;
  logic [5:0] m_gate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; hist = '{1, 1, 1}; m_is_prev = 1; m_sync_prev = 0;
      m_flag = 0; m_mask = 0; m_gate = 0;
    end else begin
      bit efall, ifall, trg, ok, srise;
      efall = hist[2] && !hist[1];
      ok    = hist[1] && isense_n;
      ifall = m_is_prev && !isense_n;
      trg   = efall || ifall || sw_wr;
      srise = sync && !m_sync_prev;
      m_gate = (trg || m_state != 0) ? 6'h00 : gate_in;
      if (sw_wr) m_flag = 1; else if (sw_rd) m_flag = 0;
      if (trg) begin
        m_state = 1; m_mask = 0;
      end else if (m_state == 1) begin
        if (ok && m_mask == 4'hF) m_state = 2;
        if (!ok) m_mask = 0; else m_mask = m_mask | we;
      end else if (m_state == 2) begin
        m_mask = 0;
        if (srise) m_state = 0;
      end else begin
        m_mask = 0;
      end
      m_is_prev = isense_n;
      m_sync_prev = sync;
      hist.push_front(trip_ext_n);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 shutdown", shutdown, m_state == 1);
      chk("R9 timer_en", timer_en, m_state != 1);
      chk("R5 gate", gate_out, m_gate);
      chk("R4 flag", sw_flag, m_flag);
      chk("R8 duty_latch", duty_latch, sync && !m_sync_prev && m_state != 1);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      gate_in = gate_in + 6'd7;
    end
  endtask

  task automatic write_reg(int idx);
    we = 4'b0001 << idx;
    idle(1);
    we = '0;
  endtask

  task automatic rearm();
    for (int i = 0; i < 4; i++) write_reg(i);
    idle(2);
    sync = 1; idle(1); sync = 0; idle(2);
  endtask

  initial begin
    #10;
    chk("R7 reset shutdown", shutdown, 0);
    chk("R5 reset gate", gate_out, 0);
    chk("R9 reset timer_en", timer_en, 1);
    chk("R4 reset flag", sw_flag, 0);
    @(posedge clk); #1; rst_n = 1;
    idle(4);
    // normal sync pulses while running
    sync = 1; #1; chk("R8 run latch", duty_latch, 1); idle(1); sync = 0; idle(3);

    // external trip
    trip_ext_n = 0; idle(2);
    chk("R1 not yet", shutdown, 0);
    idle(1);
    chk("R1 latched", shutdown, 1);
    chk("R5 idle gates", gate_out, 0);
    chk("R9 timer off", timer_en, 0);
    chk("R4 hw no flag", sw_flag, 0);
    for (int i = 0; i < 4; i++) write_reg(i);
    idle(2);
    chk("R6 writes during fault", shutdown, 1);
    trip_ext_n = 1; idle(3);
    for (int i = 0; i < 3; i++) write_reg(i);
    idle(2);
    chk("R6 three writes", shutdown, 1);
    write_reg(3);
    chk("R7 not yet armed", shutdown, 1);
    idle(1);
    chk("R7 armed", shutdown, 0);
    chk("R9 armed timer on", timer_en, 1);
    chk("R5 armed gates idle", gate_out, 0);
    idle(2);
    chk("R8 still idle w/o sync", gate_out, 0);
    sync = 1; #1; chk("R8 armed latch", duty_latch, 1);
    idle(1); sync = 0; idle(3);

    // current-sense trip, mask dropped by repeated trip
    isense_n = 0; idle(1);
    chk("R2 latched", shutdown, 1);
    isense_n = 1; idle(1);
    write_reg(0); write_reg(1);
    isense_n = 0; idle(1); isense_n = 1; idle(1);
    write_reg(2); write_reg(3);
    idle(2);
    chk("R10 mask dropped", shutdown, 1);
    rearm();
    chk("R8 running again", shutdown, 0);

    // software trip and flag
    sw_wr = 1; idle(1); sw_wr = 0;
    chk("R3 latched", shutdown, 1);
    chk("R4 flag set", sw_flag, 1);
    idle(2);
    sw_rd = 1; #1; chk("R4 flag read", sw_flag, 1);
    idle(1); sw_rd = 0;
    chk("R4 flag cleared", sw_flag, 0);
    sw_wr = 1; sw_rd = 1; idle(1); sw_wr = 0; sw_rd = 0;
    chk("R4 set wins", sw_flag, 1);
    for (int i = 0; i < 4; i++) write_reg(i);
    idle(2);
    chk("R7 armed after sw", shutdown, 0);
    // new trigger while armed
    sw_wr = 1; idle(1); sw_wr = 0;
    chk("R8 armed retrip", shutdown, 1);
    rearm();
    chk("R9 run timer", timer_en, 1);
    idle(6);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule